// File: doc/BRIEF.md
# RTC Interrupt, Status and Watchdog Controller

This block is the control side of a real-time clock. It holds the interrupt control byte and a read-only status byte. It compares three alarm latches against the running time. It selects one of fifteen periodic rates from divider taps and drives an active-low interrupt that stays asserted until software reads the status byte. It runs a watchdog that a host services by pulsing chip-enable without moving any data. It also drives the power-down outputs: supply enable, the clock-output gate and the CPU reset.

Software reaches the block through a simple register bus. The serial front end presents this bus as a write or read strobe with an address and a byte. The counters, the dividers and the analog power-fail detector are outside the block. They supply time values, single-cycle rate strobes, a watchdog time-base strobe and a power-fail strobe.

The watchdog is a three-state machine:
- **OFF** moves to **ARMED** when the enable bit is set.
- **ARMED** counts window ticks. A service returns the count to zero. On the final tick without a service it moves to **RESET** (expire).
- **RESET** holds the CPU reset low for a fixed number of cycles and then returns to **ARMED** (pulse done).
- From any state, clearing the enable bit leads to **OFF** (disable).

Power-down is a second mode, held by the power-down bit. It is entered by a write and left on any interrupt event.

Top module: `rtc_irqwd_ctrl`

## Requirements
- R1: After reset, the status byte reads 0x10 (only the first-time-up bit 4 is set), the control byte is 0x00, and int_n, pse, clkout_en and cpur_n are all high.
- R2: The control byte at address 3 can be written and read back. Its bits are: 7 watchdog enable, 6 power-down, 5 power-sense enable, 4 alarm enable, 3..0 periodic select.
- R3: With periodic select 0, no rate strobe sets a status bit or pulls int_n low.
- R4: With periodic select k in the range 1..15, a strobe on rate_tick[k-1] sets status bit 0 and bit 3, and int_n goes low one clock later. Strobes on the other taps are ignored. Taps 0..11 carry the 2048 Hz to 1 Hz rates; taps 12, 13 and 14 carry once per minute, once per hour and once per day.
- R5: A read of the status byte at address 4 returns its value and then clears every bit except bit 2. This releases int_n. Until that read, int_n stays low.
- R6: When alarm enable is set, an interrupt fires on the clock where seconds, minutes and hour bits 5..0 first equal the alarm latches (addresses 0, 1, 2). This sets status bits 1 and 3. The fire happens once per match, and alarm hour bits 7..6 are ignored. With alarm enable clear, a match has no effect.
- R7: With power-sense enable set, pf_strobe sets status bits 2 and 3. Bit 2 survives status reads. Further strobes are ignored until the control byte is written with bit 5 at 0. That write also clears bit 2.
- R8: While the power-down bit is set, pse, clkout_en and cpur_n are low, bus writes are ignored and reads return 0x00. Any interrupt event clears the power-down bit and raises the three outputs on the next clock.
- R9: With watchdog enable set, a chip-enable pulse that carries no bus access resets the window. If WIN_TICKS wd_tick strobes arrive without such a pulse, cpur_n goes low for RST_CYCLES clocks and status bit 6 is set. A pulse that carries an access does not count as a service.
- R10: Status bits 7 and 5 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 6 | Current hour code bits 5..0 (PM or tens bit in bit 5) |
| rate_tick | input | 15 | One-cycle divider strobes, tap i serves periodic select i+1 |
| wd_tick | input | 1 | One-cycle watchdog time-base strobe |
| pf_strobe | input | 1 | One-cycle power-fail indication |
| ce | input | 1 | Chip enable from the serial pins |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address: 0..2 alarm latches, 3 control, 4 status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of rd_en |
| int_n | output | 1 | Active-low interrupt request |
| pse | output | 1 | Power supply enable |
| clkout_en | output | 1 | Gate for the square-wave clock output |
| cpur_n | output | 1 | Active-low CPU reset |

## Verification
The assertions assume that rate_tick, wd_tick and pf_strobe are single-cycle strobes. They also assume that a bus strobe lasts one cycle and that rd_en and wr_en are never high together. The bench drives every strobe through tasks that raise it for exactly one clock, so these assumptions always hold. It performs bus accesses with chip-enable low, except inside the deliberate transfer-bearing pulses of the watchdog test. It changes the time inputs only between clocks, so each alarm match starts on one known edge.

// File: rtl/rtc_irqwd_pkg.sv
package rtc_irqwd_pkg;

    typedef logic [7:0] reg8_t;

    typedef enum logic [2:0] {
        A_ASEC = 3'd0,
        A_AMIN = 3'd1,
        A_AHR  = 3'd2,
        A_ICTL = 3'd3,
        A_STAT = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        WD_OFF,
        WD_ARMED,
        WD_RESET
    } wd_state_e;

    localparam int B_WD  = 7;
    localparam int B_PD  = 6;
    localparam int B_PSE = 5;
    localparam int B_ALM = 4;

endpackage

// File: rtl/rtc_rate_sel.sv
module rtc_rate_sel #(
    parameter int SEL_W = 4,
    localparam int N_RATES = (1 << SEL_W) - 1
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic [N_RATES-1:0] taps,
    output logic               hit
);
    logic [N_RATES-1:0] pick;

    for (genvar i = 0; i < N_RATES; i++) begin : g_tap
        assign pick[i] = taps[i] && (sel == SEL_W'(i + 1));
    end

    assign hit = |pick;
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [7:0] cur_sec,
    input  logic [7:0] cur_min,
    input  logic [5:0] cur_hour,
    input  logic [7:0] alm_sec,
    input  logic [7:0] alm_min,
    input  logic [5:0] alm_hour,
    output logic       fire
);
    logic match, match_q;

    assign match = (cur_sec == alm_sec) && (cur_min == alm_min)
                && (cur_hour == alm_hour);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= match;
    end

    // one event on the first cycle of a match only
    assign fire = enable && match && !match_q;
endmodule

// File: rtl/rtc_wdog_fsm.sv
module rtc_wdog_fsm
    import rtc_irqwd_pkg::*;
#(
    parameter int WIN_TICKS  = 4,
    parameter int RST_CYCLES = 8,
    localparam int CW  = $clog2(WIN_TICKS + 1),
    localparam int RCW = $clog2(RST_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ce,
    input  logic xfer,
    input  logic tick,
    output logic rst_act,
    output logic fire
);
    wd_state_e state_q, state_d;
    logic          ce_q, busy_q, service;
    logic [CW-1:0] win_q;
    logic [RCW-1:0] pulse_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_q   <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            ce_q <= ce;
            if (ce && !ce_q)   busy_q <= xfer;
            else if (ce && xfer) busy_q <= 1'b1;
        end
    end

    assign service = !ce && ce_q && !busy_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_OFF:   if (enable) state_d = WD_ARMED;
            WD_ARMED: begin
                if (!enable) state_d = WD_OFF;
                else if (tick && !service && win_q == CW'(WIN_TICKS - 1))
                    state_d = WD_RESET;
            end
            WD_RESET: begin
                if (!enable) state_d = WD_OFF;
                else if (pulse_q == RCW'(RST_CYCLES - 1)) state_d = WD_ARMED;
            end
            default:  state_d = WD_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_OFF;
            win_q   <= '0;
            pulse_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != WD_ARMED || service) win_q <= '0;
            else if (tick)                      win_q <= win_q + 1'b1;
            if (state_q == WD_RESET) pulse_q <= pulse_q + 1'b1;
            else                     pulse_q <= '0;
        end
    end

    always_comb begin
        rst_act = (state_q == WD_RESET);
        fire    = (state_q == WD_ARMED) && (state_d == WD_RESET);
    end
endmodule

// File: rtl/rtc_irqwd_ctrl.sv
module rtc_irqwd_ctrl
    import rtc_irqwd_pkg::*;
#(
    parameter int SEL_W      = 4,
    parameter int WIN_TICKS  = 4,
    parameter int RST_CYCLES = 8,
    localparam int N_RATES = (1 << SEL_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         cur_sec,
    input  logic [7:0]         cur_min,
    input  logic [5:0]         cur_hour,
    input  logic [N_RATES-1:0] rate_tick,
    input  logic               wd_tick,
    input  logic               pf_strobe,
    input  logic               ce,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [2:0]         addr,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    output logic               int_n,
    output logic               pse,
    output logic               clkout_en,
    output logic               cpur_n
);
    reg8_t      ictl_q, alm_sec_q, alm_min_q;
    logic [5:0] alm_hr_q;
    logic st_wd, st_ftu, st_true, st_ps, st_alm, st_per;
    logic ps_armed_q;
    logic pd, wr_ok, wr_ictl, rd_stat;
    logic per_hit, alm_fire, ps_fire, ev_any, wd_rst, wd_fire;

    assign pd      = ictl_q[B_PD];
    assign wr_ok   = wr_en && !pd;
    assign wr_ictl = wr_ok && (addr == A_ICTL);
    assign rd_stat = rd_en && !pd && (addr == A_STAT);

    rtc_rate_sel #(.SEL_W(SEL_W)) u_rate (
        .sel  (ictl_q[SEL_W-1:0]),
        .taps (rate_tick),
        .hit  (per_hit)
    );

    rtc_alarm_cmp u_alarm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (ictl_q[B_ALM]),
        .cur_sec  (cur_sec),
        .cur_min  (cur_min),
        .cur_hour (cur_hour),
        .alm_sec  (alm_sec_q),
        .alm_min  (alm_min_q),
        .alm_hour (alm_hr_q),
        .fire     (alm_fire)
    );

    rtc_wdog_fsm #(.WIN_TICKS(WIN_TICKS), .RST_CYCLES(RST_CYCLES)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (ictl_q[B_WD]),
        .ce      (ce),
        .xfer    (wr_en || rd_en),
        .tick    (wd_tick),
        .rst_act (wd_rst),
        .fire    (wd_fire)
    );

    assign ps_fire = pf_strobe && ictl_q[B_PSE] && ps_armed_q;
    assign ev_any  = per_hit || alm_fire || ps_fire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ictl_q     <= '0;
            alm_sec_q  <= '0;
            alm_min_q  <= '0;
            alm_hr_q   <= '0;
            ps_armed_q <= 1'b1;
        end else begin
            if (wr_ok) begin
                case (addr)
                    A_ASEC:  alm_sec_q <= wdata;
                    A_AMIN:  alm_min_q <= wdata;
                    A_AHR:   alm_hr_q  <= wdata[5:0];
                    A_ICTL:  ictl_q    <= wdata;
                    default: ;
                endcase
            end
            if (ev_any) ictl_q[B_PD] <= 1'b0;
            if (ps_fire)                        ps_armed_q <= 1'b0;
            else if (wr_ictl && !wdata[B_PSE])  ps_armed_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_wd   <= 1'b0;
            st_ftu  <= 1'b1;
            st_true <= 1'b0;
            st_ps   <= 1'b0;
            st_alm  <= 1'b0;
            st_per  <= 1'b0;
        end else begin
            if (rd_stat) begin
                st_wd   <= 1'b0;
                st_ftu  <= 1'b0;
                st_true <= 1'b0;
                st_alm  <= 1'b0;
                st_per  <= 1'b0;
            end
            if (wr_ictl && !wdata[B_PSE]) st_ps <= 1'b0;
            if (per_hit)  st_per  <= 1'b1;
            if (alm_fire) st_alm  <= 1'b1;
            if (ps_fire)  st_ps   <= 1'b1;
            if (ev_any)   st_true <= 1'b1;
            if (wd_fire)  st_wd   <= 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        if (!pd) begin
            case (addr)
                A_ICTL:  rdata = ictl_q;
                A_STAT:  rdata = {1'b0, st_wd, 1'b0, st_ftu, st_true, st_ps, st_alm, st_per};
                default: rdata = '0;
            endcase
        end
    end

    assign int_n     = !st_true;
    assign pse       = !pd;
    assign clkout_en = !pd;
    assign cpur_n    = !(pd || wd_rst);
endmodule

// File: rtl/rtc_irqwd_chk.sv
module rtc_irqwd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_en,
    input logic [2:0] addr,
    input logic [7:0] rdata,
    input logic       int_n,
    input logic       pse,
    input logic       cpur_n,
    input logic       ev_any,
    input logic [7:0] ictl
);
    logic rd_st;
    assign rd_st = rd_en && pse && (addr == 3'd4);

    AST_INT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_n && !rd_st) |=> !int_n);  // R5
    AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_st && !ev_any) |=> int_n);  // R5
    AST_PD_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (!pse && ev_any) |=> pse);  // R8
    AST_PD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!pse && !ev_any) |=> $stable(ictl));  // R8
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_st |-> (rdata[7] == 1'b0 && rdata[5] == 1'b0));  // R10
    AST_WD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ictl[7] && !$past(ictl[7]) && pse) |-> cpur_n);  // R9
endmodule

bind rtc_irqwd_ctrl rtc_irqwd_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (rd_en),
    .addr   (addr),
    .rdata  (rdata),
    .int_n  (int_n),
    .pse    (pse),
    .cpur_n (cpur_n),
    .ev_any (ev_any),
    .ictl   (ictl_q)
);

// File: tb/rtc_irqwd_ctrl_test.sv
module rtc_irqwd_ctrl_test;
    localparam int RSTC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cur_sec = 8'h00, cur_min = 8'h00;
    logic [5:0]  cur_hour = 6'h00;
    logic [14:0] rate_tick = '0;
    logic        wd_tick = 1'b0, pf_strobe = 1'b0, ce = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        int_n, pse, clkout_en, cpur_n;

    int applied = 0;
    int errors  = 0;

    typedef struct {
        string      tag;
        logic [7:0] exp;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    rtc_irqwd_ctrl #(.WIN_TICKS(4), .RST_CYCLES(RSTC)) uut (
        .clk(clk), .rst_n(rst_n), .cur_sec(cur_sec), .cur_min(cur_min),
        .cur_hour(cur_hour), .rate_tick(rate_tick), .wd_tick(wd_tick),
        .pf_strobe(pf_strobe), .ce(ce), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .int_n(int_n),
        .pse(pse), .clkout_en(clkout_en), .cpur_n(cpur_n)
    );

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // driver side: record what should be seen
    task automatic expect_v(input string tag, input logic [7:0] e);
        item_t it;
        it.tag = tag;
        it.exp = e;
        sb.push_back(it);
    endtask

    // monitor side: compare the next observation with the oldest expectation
    task automatic observe(input logic [7:0] act);
        item_t it;
        it = sb.pop_front();
        applied++;
        if (act !== it.exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
        end
    endtask

    task automatic see(input string tag, input logic [7:0] act, input logic [7:0] e);
        expect_v(tag, e);
        observe(act);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string tag);
        expect_v(tag, e);
        rd_en = 1'b1; addr = a;
        #1;
        observe(rdata);
        cyc();
        rd_en = 1'b0;
    endtask

    task automatic tap(input int i);
        rate_tick[i] = 1'b1;
        cyc();
        rate_tick = '0;
    endtask

    task automatic wdt();
        wd_tick = 1'b1;
        cyc();
        wd_tick = 1'b0;
    endtask

    task automatic pf();
        pf_strobe = 1'b1;
        cyc();
        pf_strobe = 1'b0;
    endtask

    task automatic ce_pulse(input bit with_xfer);
        ce = 1'b1;
        cyc();
        if (with_xfer) begin
            rd_en = 1'b1; addr = 3'd3;
            cyc();
            rd_en = 1'b0;
        end
        cyc();
        ce = 1'b0;
        cyc(2);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        see("R1 int_n", {7'd0, int_n}, 8'h01);
        see("R1 pse", {7'd0, pse}, 8'h01);
        see("R1 clkout_en", {7'd0, clkout_en}, 8'h01);
        see("R1 cpur_n", {7'd0, cpur_n}, 8'h01);
        rd_chk(3'd3, 8'h00, "R1 control");
        rd_chk(3'd4, 8'h10, "R1 status");
        rd_chk(3'd4, 8'h00, "R5 cleared first-time-up");

        // R2 readback
        wr(3'd3, 8'h1D);
        rd_chk(3'd3, 8'h1D, "R2 readback");
        wr(3'd3, 8'h00);

        // R3 select 0
        rate_tick = '1;
        cyc();
        rate_tick = '0;
        see("R3 int_n", {7'd0, int_n}, 8'h01);
        rd_chk(3'd4, 8'h00, "R3 status");

        // R4 select 13 -> tap 12 (minute)
        wr(3'd3, 8'h0D);
        tap(11);
        see("R4 other tap", {7'd0, int_n}, 8'h01);
        tap(12);
        see("R4 int_n low", {7'd0, int_n}, 8'h00);
        cyc(3);
        see("R5 int held", {7'd0, int_n}, 8'h00);
        rd_chk(3'd4, 8'h09, "R4 status");
        see("R5 int released", {7'd0, int_n}, 8'h01);
        wr(3'd3, 8'h01);
        tap(0);
        rd_chk(3'd4, 8'h09, "R4 select 1");

        // R6 alarm, hour bits 7..6 of latch set to show they are ignored
        wr(3'd3, 8'h00);
        cur_sec = 8'h29; cur_min = 8'h15; cur_hour = 6'h03;
        wr(3'd0, 8'h30);
        wr(3'd1, 8'h15);
        wr(3'd2, 8'hC3);
        wr(3'd3, 8'h10);
        see("R6 no match", {7'd0, int_n}, 8'h01);
        cur_sec = 8'h30;
        cyc();
        see("R6 alarm int", {7'd0, int_n}, 8'h00);
        rd_chk(3'd4, 8'h0A, "R6 status");
        cyc(4);
        rd_chk(3'd4, 8'h00, "R6 single fire");
        cur_sec = 8'h31; cur_hour = 6'h23;
        cyc();
        cur_sec = 8'h30;
        cyc();
        rd_chk(3'd4, 8'h00, "R6 PM mismatch");
        wr(3'd3, 8'h00);
        cur_sec = 8'h31; cur_hour = 6'h03;
        cyc();
        cur_sec = 8'h30;
        cyc();
        rd_chk(3'd4, 8'h00, "R6 disabled");

        // R7 power sense
        wr(3'd3, 8'h20);
        pf();
        see("R7 int", {7'd0, int_n}, 8'h00);
        rd_chk(3'd4, 8'h0C, "R7 status");
        rd_chk(3'd4, 8'h04, "R7 sticky");
        pf();
        see("R7 not rearmed int", {7'd0, int_n}, 8'h01);
        rd_chk(3'd4, 8'h04, "R7 not rearmed");
        wr(3'd3, 8'h00);
        rd_chk(3'd4, 8'h00, "R7 rearm clears");
        wr(3'd3, 8'h20);
        pf();
        rd_chk(3'd4, 8'h0C, "R7 refire");
        wr(3'd3, 8'h00);

        // R8 power-down
        wr(3'd3, 8'h41);
        see("R8 pse", {7'd0, pse}, 8'h00);
        see("R8 clkout_en", {7'd0, clkout_en}, 8'h00);
        see("R8 cpur_n", {7'd0, cpur_n}, 8'h00);
        wr(3'd3, 8'h00);
        see("R8 write ignored", {7'd0, pse}, 8'h00);
        rd_chk(3'd3, 8'h00, "R8 read zero");
        tap(0);
        see("R8 wake pse", {7'd0, pse}, 8'h01);
        see("R8 wake cpur_n", {7'd0, cpur_n}, 8'h01);
        see("R8 wake clkout_en", {7'd0, clkout_en}, 8'h01);
        rd_chk(3'd3, 8'h01, "R8 control after wake");
        rd_chk(3'd4, 8'h09, "R8 wake status");
        wr(3'd3, 8'h00);

        // R9 watchdog
        wr(3'd3, 8'h80);
        cyc();
        for (int k = 0; k < 6; k++) begin
            wdt();
            ce_pulse(1'b0);
        end
        see("R9 serviced", {7'd0, cpur_n}, 8'h01);
        ce_pulse(1'b0);
        for (int k = 0; k < 3; k++) begin
            wdt();
            ce_pulse(1'b1);
        end
        see("R9 before expiry", {7'd0, cpur_n}, 8'h01);
        wdt();
        see("R9 reset low", {7'd0, cpur_n}, 8'h00);
        cyc(RSTC - 2);
        see("R9 reset held", {7'd0, cpur_n}, 8'h00);
        cyc(2);
        see("R9 reset released", {7'd0, cpur_n}, 8'h01);
        rd_chk(3'd4, 8'h40, "R9 R10 status");
        wr(3'd3, 8'h00);

        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual %0d expected 0", sb.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
    end
endmodule